// File: doc/BRIEF.md
# Configurable Six-Pin I/O Port Controller

This block holds the configuration state and data path of a small general-purpose I/O port. For every pin it keeps a direction bit, an analog-select bit and a pull-up enable bit. It also keeps one global pull-up disable bit and an output data latch. From this state it produces registered per-pin output-enable, output-data and pull-up-enable signals for the pad ring. The pad input values pass through a synchronizer, and digital port reads return them with analog-selected pins forced to zero.

Two conditions outside the register bank override the stored state. A clock-mode input marks up to two pins as claimed by the oscillator. A claimed pin reads back as an input and never drives. A reset-pin mode input decides whether the input-only pin serves as the chip reset input. When it does, that pin gets a pull-up that no register bit can turn off.

A narrow register bus with a 2-bit address gives write and read access. Read data is registered and appears one cycle after the read strobe. It then holds until the next read.

Top module: `iop_port`

## Requirements
- R1: After reset, every pin's direction reads 1 and the output latch is 0. Reads return direction 0x3F, analog select 0x37 and pull-up register 0xB7. No pin drives.
- R2: A direction bit of 0 makes the pin drive its latch value (pad_oe bit 1). A direction bit of 1 tri-states it (pad_oe bit 0). Outputs follow a register write after one further clock.
- R3: Pin 3 is input only. Its direction bit always reads 1, its pad_oe is always 0, and direction bits 7:6 always read 0.
- R4: Clock-mode codes are LP=0, XT=1, HS=2, EC=3, INT=4, INT_IO=5, RC=6, RC_IO=7. In LP, XT and HS, pins 4 and 5 read back as inputs and do not drive. In EC, RC and RC_IO, only pin 5 does so. In INT and INT_IO, no pin is claimed.
- R5: A port read (address 0) returns the synchronized pin levels, with every analog-selected pin read as 0.
- R6: The analog-select bits have no effect on pad_oe or pad_out.
- R7: For a pin other than 3, the pull-up is on only when its enable bit is 1, the global disable bit is 0, and the pin is an input. A driving pin never has its pull-up on.
- R8: The global pull-up disable bit is bit 7 of the pull-up register and resets to 1. While it is 1, the pull-ups of pins 0, 1, 2, 4 and 5 are off.
- R9: Pin 3's pull-up equals the reset-pin mode input, whatever the register contents.
- R10: A write to address 0 loads the output latch, which drives pad_out.
- R11: Addresses are 0 = port data, 1 = direction, 2 = analog select, 3 = pull-up. Analog-select bit 3 and bits 7:6 read 0. Pull-up bits 3 and 6 read 0. Writes to these bits are ignored.
- R12: Read data appears one clock after the read strobe and holds until the next read. A pin change reaches port reads only after the synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| osc_mode | input | 3 | Clock-mode code |
| rst_pin_mode | input | 1 | 1 when pin 3 serves as the reset input |
| pad_in | input | 6 | Pin levels from the pads |
| pad_oe | output | 6 | Per-pin output enable |
| pad_out | output | 6 | Per-pin output data |
| pad_pu | output | 6 | Per-pin weak pull-up enable |

## Verification
The bench uses the default parameters: six pins, an 8-bit register bus, two synchronizer stages, pin 3 as the input-only pin and pins 4 and 5 as oscillator pins. With these values the same run covers several cases: the unimplemented gap at bit 6 and the global disable at bit 7 sit in one byte, and both claim patterns of the clock modes fall on pins that also have pull-up and analog bits. The two-stage synchronizer makes the stale-read window short enough to test with directed reads.

// File: rtl/iop_pkg.sv
package iop_pkg;

  typedef enum logic [2:0] {
    OSC_LP     = 3'd0,
    OSC_XT     = 3'd1,
    OSC_HS     = 3'd2,
    OSC_EC     = 3'd3,
    OSC_INT    = 3'd4,
    OSC_INT_IO = 3'd5,
    OSC_RC     = 3'd6,
    OSC_RC_IO  = 3'd7
  } osc_mode_e;

  typedef enum logic [1:0] {
    REG_PORT = 2'd0,
    REG_DIR  = 2'd1,
    REG_ANA  = 2'd2,
    REG_PULL = 2'd3
  } reg_sel_e;

  localparam int BUS_AW = 2;

endpackage

// File: rtl/iop_regs.sv
module iop_regs
  import iop_pkg::*;
#(
  parameter int NPINS      = 6,
  parameter int DW         = 8,
  parameter int INONLY_PIN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [BUS_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [NPINS-1:0]  latch_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  ana_q,
  output logic [NPINS-1:0]  pu_en_q,
  output logic              pull_off_q
);

  // pins that own an analog/pull-up bit: all but the input-only pin
  localparam logic [NPINS-1:0] OWN_MASK = ~(NPINS'(1) << INONLY_PIN);

  // bits between the pin field and the global disable bit are never stored
  logic unused_wdata_gap;
  assign unused_wdata_gap = ^wdata[DW-2:NPINS];

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q    <= '0;
      dir_q      <= '1;
      ana_q      <= OWN_MASK;
      pu_en_q    <= OWN_MASK;
      pull_off_q <= 1'b1;
    end else if (wr) begin
      unique case (reg_sel_e'(addr))
        REG_PORT: latch_q <= wdata[NPINS-1:0];
        REG_DIR:  dir_q   <= wdata[NPINS-1:0] | ~OWN_MASK;
        REG_ANA:  ana_q   <= wdata[NPINS-1:0] & OWN_MASK;
        REG_PULL: begin
          pu_en_q    <= wdata[NPINS-1:0] & OWN_MASK;
          pull_off_q <= wdata[DW-1];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/iop_claim.sv
module iop_claim
  import iop_pkg::*;
#(
  parameter int NPINS      = 6,
  parameter int CLK_PIN_A  = 4,
  parameter int CLK_PIN_B  = 5
) (
  input  logic [2:0]       mode,
  output logic [NPINS-1:0] claim
);

  localparam logic [NPINS-1:0] BIT_A = NPINS'(1) << CLK_PIN_A;
  localparam logic [NPINS-1:0] BIT_B = NPINS'(1) << CLK_PIN_B;

  always_comb begin
    unique case (osc_mode_e'(mode))
      OSC_LP, OSC_XT, OSC_HS:    claim = BIT_A | BIT_B;
      OSC_EC, OSC_RC, OSC_RC_IO: claim = BIT_B;
      default:                   claim = '0;
    endcase
  end

endmodule

// File: rtl/iop_pin_slice.sv
module iop_pin_slice #(
  parameter bit IS_INONLY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic dir,
  input  logic claimed,
  input  logic latch,
  input  logic pu_en,
  input  logic pull_off,
  input  logic rst_pin_mode,
  output logic eff_dir,
  output logic oe_q,
  output logic out_q,
  output logic pu_q
);

  logic oe_d, pu_d;

  assign eff_dir = IS_INONLY ? 1'b1 : (dir | claimed);
  assign oe_d    = IS_INONLY ? 1'b0 : ~eff_dir;
  assign pu_d    = IS_INONLY ? rst_pin_mode : (pu_en & ~pull_off & eff_dir);

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      out_q <= 1'b0;
      pu_q  <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      out_q <= latch;
      pu_q  <= pu_d;
    end
  end

endmodule

// File: rtl/iop_readback.sv
module iop_readback
  import iop_pkg::*;
#(
  parameter int NPINS       = 6,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [BUS_AW-1:0] addr,
  input  logic [NPINS-1:0]  pad_in,
  input  logic [NPINS-1:0]  eff_dir,
  input  logic [NPINS-1:0]  ana_q,
  input  logic [NPINS-1:0]  pu_en_q,
  input  logic              pull_off_q,
  output logic [DW-1:0]     rdata_q
);

  logic [NPINS-1:0] sync_q [SYNC_STAGES];
  logic [DW-1:0]    rd_mux;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= pad_in;
      else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_sel_e'(addr))
      REG_PORT: rd_mux[NPINS-1:0] = sync_q[SYNC_STAGES-1] & ~ana_q;
      REG_DIR:  rd_mux[NPINS-1:0] = eff_dir;
      REG_ANA:  rd_mux[NPINS-1:0] = ana_q;
      REG_PULL: begin
        rd_mux[NPINS-1:0] = pu_en_q;
        rd_mux[DW-1]      = pull_off_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

endmodule

// File: rtl/iop_port.sv
module iop_port
  import iop_pkg::*;
#(
  parameter int NPINS       = 6,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int INONLY_PIN  = 3,
  parameter int CLK_PIN_A   = 4,
  parameter int CLK_PIN_B   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [2:0]       osc_mode,
  input  logic             rst_pin_mode,
  input  logic [5:0]       pad_in,
  output logic [5:0]       pad_oe,
  output logic [5:0]       pad_out,
  output logic [5:0]       pad_pu
);

  logic [NPINS-1:0] latch_q, dir_q, ana_q, pu_en_q, claim, eff_dir;
  logic             pull_off_q;

  iop_regs #(
    .NPINS(NPINS), .DW(DW), .INONLY_PIN(INONLY_PIN)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .latch_q(latch_q), .dir_q(dir_q), .ana_q(ana_q),
    .pu_en_q(pu_en_q), .pull_off_q(pull_off_q)
  );

  iop_claim #(
    .NPINS(NPINS), .CLK_PIN_A(CLK_PIN_A), .CLK_PIN_B(CLK_PIN_B)
  ) u_claim (
    .mode(osc_mode), .claim(claim)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    iop_pin_slice #(
      .IS_INONLY(p == INONLY_PIN)
    ) u_slice (
      .clk(clk), .rst(rst),
      .dir(dir_q[p]), .claimed(claim[p]), .latch(latch_q[p]),
      .pu_en(pu_en_q[p]), .pull_off(pull_off_q), .rst_pin_mode(rst_pin_mode),
      .eff_dir(eff_dir[p]),
      .oe_q(pad_oe[p]), .out_q(pad_out[p]), .pu_q(pad_pu[p])
    );
  end

  iop_readback #(
    .NPINS(NPINS), .DW(DW), .SYNC_STAGES(SYNC_STAGES)
  ) u_rb (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr), .pad_in(pad_in),
    .eff_dir(eff_dir), .ana_q(ana_q), .pu_en_q(pu_en_q),
    .pull_off_q(pull_off_q), .rdata_q(bus_rdata)
  );

endmodule

// File: rtl/iop_port_chk.sv
module iop_port_chk
  import iop_pkg::*;
#(
  parameter int NPINS      = 6,
  parameter int DW         = 8,
  parameter int INONLY_PIN = 3,
  parameter int CLK_PIN_A  = 4,
  parameter int CLK_PIN_B  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       bus_addr,
  input logic             bus_rd,
  input logic [DW-1:0]    bus_rdata,
  input logic [2:0]       osc_mode,
  input logic             rst_pin_mode,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_pu
);

  localparam logic [NPINS-1:0] OTHERS = ~(NPINS'(1) << INONLY_PIN);

  AST_INONLY_NEVER_DRIVES: assert property (@(posedge clk) disable iff (rst)
    !pad_oe[INONLY_PIN]); // R3

  AST_NO_PULL_WHILE_DRIVING: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & pad_pu & OTHERS) == '0)); // R7

  AST_RESET_PIN_PULL: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pad_pu[INONLY_PIN] == $past(rst_pin_mode))); // R9

  AST_CRYSTAL_CLAIM: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(osc_mode) == OSC_LP || $past(osc_mode) == OSC_XT ||
                     $past(osc_mode) == OSC_HS))
    |-> (!pad_oe[CLK_PIN_A] && !pad_oe[CLK_PIN_B])); // R4

  AST_DIR_READ_SHAPE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && bus_rd && bus_addr == REG_DIR)
    |-> (bus_rdata[DW-1:NPINS] == '0 && bus_rdata[INONLY_PIN])); // R3

endmodule

bind iop_port iop_port_chk #(
  .NPINS(NPINS), .DW(DW), .INONLY_PIN(INONLY_PIN),
  .CLK_PIN_A(CLK_PIN_A), .CLK_PIN_B(CLK_PIN_B)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .osc_mode(osc_mode), .rst_pin_mode(rst_pin_mode),
  .pad_oe(pad_oe), .pad_pu(pad_pu)
);

// File: tb/sim_iop_port.sv
module sim_iop_port;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] osc_mode = 3'd5;
  logic       rst_pin_mode = 1'b1;
  logic [5:0] pad_in = '0;
  logic [5:0] pad_oe, pad_out, pad_pu;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  iop_port u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .osc_mode(osc_mode), .rst_pin_mode(rst_pin_mode), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    settle();
    chk("R1 oe after reset", {2'b0, pad_oe}, 8'h00);
    chk("R1 latch after reset", {2'b0, pad_out}, 8'h00);
    chk("R8/R9 pull after reset", {2'b0, pad_pu}, 8'h08);
    rd(2'd1, v); chk("R1 dir read", v, 8'h3F);
    rd(2'd2, v); chk("R1 analog read", v, 8'h37);
    rd(2'd3, v); chk("R1 R8 pull read", v, 8'hB7);
  endtask

  task automatic t_drive();
    logic [7:0] v;
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h2A);
    settle();
    chk("R2 all drive", {2'b0, pad_oe}, 8'h37);
    chk("R10 latch drives", {2'b0, pad_out}, 8'h2A);
    rd(2'd1, v); chk("R3 input-only reads 1", v, 8'h08);
    wr(2'd1, 8'hF8);
    settle();
    chk("R2 partial drive", {2'b0, pad_oe}, 8'h07);
    rd(2'd1, v); chk("R3 high dir bits read 0", v, 8'h38);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_osc();
    logic [7:0] v;
    osc_mode = 3'd1;
    settle();
    chk("R4 XT oe", {2'b0, pad_oe}, 8'h07);
    rd(2'd1, v); chk("R4 XT dir read", v, 8'h38);
    osc_mode = 3'd6;
    settle();
    chk("R4 RC oe", {2'b0, pad_oe}, 8'h17);
    rd(2'd1, v); chk("R4 RC dir read", v, 8'h28);
    osc_mode = 3'd5;
    settle();
    chk("R4 INT_IO oe", {2'b0, pad_oe}, 8'h37);
  endtask

  task automatic t_analog();
    logic [7:0] v;
    pad_in = 6'h3F;
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R11 analog unimpl bits", v, 8'h37);
    rd(2'd0, v); chk("R5 analog masks read", v, 8'h08);
    chk("R6 oe unchanged", {2'b0, pad_oe}, 8'h37);
    chk("R6 out unchanged", {2'b0, pad_out}, 8'h2A);
    wr(2'd2, 8'h0D);
    rd(2'd0, v); chk("R5 partial mask", v, 8'h3A);
  endtask

  task automatic t_pullup();
    logic [7:0] v;
    rst_pin_mode = 1'b0;
    wr(2'd1, 8'h3F);
    wr(2'd3, 8'h17);
    rd(2'd3, v); chk("R11 pull read", v, 8'h17);
    settle();
    chk("R7 enabled inputs pulled", {2'b0, pad_pu}, 8'h17);
    wr(2'd1, 8'h01);
    settle();
    chk("R7 outputs not pulled", {2'b0, pad_pu}, 8'h01);
    wr(2'd1, 8'h3F);
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R11 pull unimpl bits", v, 8'hB7);
    settle();
    chk("R8 global disable", {2'b0, pad_pu}, 8'h00);
    wr(2'd3, 8'h7F);
    settle();
    chk("R7 global enable", {2'b0, pad_pu}, 8'h37);
  endtask

  task automatic t_pin3();
    rst_pin_mode = 1'b1;
    settle();
    chk("R9 reset pin pulled", {2'b0, pad_pu}, 8'h3F);
    wr(2'd3, 8'hFF);
    settle();
    chk("R9 reset pin pull ignores global", {2'b0, pad_pu}, 8'h08);
  endtask

  task automatic t_sync();
    logic [7:0] v;
    wr(2'd2, 8'h00);
    settle();
    @(negedge clk);
    pad_in = 6'h15; bus_addr = 2'd0; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R12 stale during sync", bus_rdata, 8'h3F);
    repeat (2) @(negedge clk);
    rd(2'd0, v); chk("R12 new value after sync", v, 8'h15);
    pad_in = 6'h00;
    repeat (4) @(negedge clk);
    chk("R12 read data holds", bus_rdata, 8'h15);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_drive();
    t_osc();
    t_analog();
    t_pullup();
    t_pin3();
    t_sync();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule